// File: doc/BRIEF.md
# Write-Cycle Qualifier for a Parallel Memory Port

This block sits between the asynchronous control pins of a parallel memory port and the command state machine behind it. It samples the active-low chip-select, read-enable and write-enable pins with a fast clock. It passes them through a synchronizer and decides whether a real write cycle took place. When one did, it hands the state machine a single-clock write strobe. A write counts only when chip-select and write-enable are both low while read-enable is high, and only when that combination persists long enough to rule out noise.

Power-good arrives as a digital level. While it is low, no strobe is produced. Each time power-good rises, the block sends a one-clock pulse that returns the downstream state machine to read mode. A write that is already asserted on the pins when power becomes good is never accepted. The block arms only after it has seen the pins leave the write combination at least once.

Top module: `wrq_gate`

## Requirements
- R1: During and directly after reset, `wr_strobe` and `rd_mode_rst` are low.
- R2: A write is recognised only for the pin combination `ce_n`=0, `we_n`=0, `oe_n`=1. When that combination ends after being held for at least `MIN_CYC` clocks, exactly one strobe follows.
- R3: Of the eight pin combinations held for a long time, only the combination in R2 produces a strobe. Each of `oe_n`=0, `ce_n`=1 or `we_n`=1 alone blocks the write.
- R4: The write combination is rejected as noise when it lasts fewer than `MIN_CYC` clocks. This holds whether the short pulse is on `we_n`, on `ce_n` or (as a high pulse) on `oe_n`. A duration of `MIN_CYC` clocks or more is accepted.
- R5: `wr_strobe` is high for exactly one clock per accepted write.
- R6: While `pwr_good` is low, no strobe is produced.
- R7: If the write combination is already present when `pwr_good` rises, ending it produces no strobe. The next complete write after the pins have left the combination is accepted.
- R8: Every rising edge of `pwr_good` yields exactly one one-clock `rd_mode_rst` pulse. No pulse occurs while `pwr_good` stays steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| pwr_good | input | 1 | Supply is valid (level) |
| ce_n | input | 1 | Raw chip-select pin, active low |
| oe_n | input | 1 | Raw read-enable pin, active low |
| we_n | input | 1 | Raw write-enable pin, active low |
| wr_strobe | output | 1 | One-clock pulse per qualified write |
| rd_mode_rst | output | 1 | One-clock pulse forcing read mode on power-up |

## Verification
The bench sweeps the duration of the write combination from 1 to 6 clocks, using `MIN_CYC` = 3. It opens the window three ways: with a write-enable pulse, with a chip-select pulse, and with a read-enable high pulse. This separates a correct noise threshold from an off-by-one at either end of the threshold. The bench also checks that the filter watches the combined condition and not just one pin. It holds all eight pin combinations in turn, which separates the exact three-pin rule from a rule that looks at fewer pins. Power-good sequences check three cases: a write held across the power-good rise, a write made while power is bad, and a normal write after arming. These cases separate the arming rule from a plain gate on power-good.

// File: rtl/wrq_pkg.sv
package wrq_pkg;
   // bit positions inside the sampled pin vector
   localparam int PIN_CE = 0;
   localparam int PIN_OE = 1;
   localparam int PIN_WE = 2;
   localparam int PIN_PG = 3;
   localparam int PIN_COUNT = 4;

   // write condition: chip-select low, write-enable low, read-enable high
   function automatic logic write_cond(input logic [PIN_COUNT-1:0] s);
      return ~s[PIN_CE] & ~s[PIN_WE] & s[PIN_OE];
   endfunction
endpackage

// File: rtl/wrq_sync.sv
module wrq_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw,
   input  logic [WIDTH-1:0] rst_val,
   output logic [WIDTH-1:0] sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wrq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("wrq_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{rst_val[b]}};
         else        chain <= {chain[STAGES-2:0], raw[b]};
      end
      assign sync[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/wrq_width.sv
module wrq_width #(
   parameter int MIN_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   output logic long_enough
);
   localparam int CW = $clog2(MIN_CYC + 1);

   if (MIN_CYC < 1) begin : g_bad_min
      $error("wrq_width: MIN_CYC must be at least 1");
   end

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          run_cnt <= '0;
      else if (!cond)                      run_cnt <= '0;
      else if (run_cnt < CW'(MIN_CYC))     run_cnt <= run_cnt + 1'b1;
   end

   assign long_enough = (run_cnt >= CW'(MIN_CYC));

   // R4: a qualified run means the condition was present on the previous clock
   run_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      long_enough |-> $past(cond));
endmodule

// File: rtl/wrq_arm.sv
module wrq_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic pg,
   input  logic cond,
   output logic armed,
   output logic pg_rise
);
   logic pg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         pg_q    <= 1'b0;
         pg_rise <= 1'b0;
      end else begin
         pg_q    <= pg;
         pg_rise <= pg & ~pg_q;
         if (!pg)       armed <= 1'b0;
         else if (!cond) armed <= 1'b1;
      end
   end

   // R7: arming only happens after the pins left the write combination
   arm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(!cond) && $past(pg));
   // R8: read-mode pulse lasts one clock
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pg_rise |=> !pg_rise);
endmodule

// File: rtl/wrq_gate.sv
module wrq_gate #(
   parameter int MIN_CYC = 2,
   parameter int STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   output logic wr_strobe,
   output logic rd_mode_rst
);
   import wrq_pkg::*;

   logic [PIN_COUNT-1:0] raw_pins, sync_pins, idle_val;
   logic cond, cond_q, long_enough, armed, pg_s;

   assign raw_pins = {pwr_good, we_n, oe_n, ce_n};
   // control pins rest high (inactive), power-good rests low
   assign idle_val = {1'b0, 1'b1, 1'b1, 1'b1};

   wrq_sync #(.WIDTH(PIN_COUNT), .STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(raw_pins), .rst_val(idle_val), .sync(sync_pins));

   assign pg_s = sync_pins[PIN_PG];
   assign cond = write_cond(sync_pins);

   wrq_width #(.MIN_CYC(MIN_CYC)) u_width (
      .clk(clk), .rst_n(rst_n), .cond(cond), .long_enough(long_enough));

   wrq_arm u_arm (
      .clk(clk), .rst_n(rst_n), .pg(pg_s), .cond(cond),
      .armed(armed), .pg_rise(rd_mode_rst));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q    <= 1'b0;
         wr_strobe <= 1'b0;
      end else begin
         cond_q    <= cond;
         wr_strobe <= pg_s & armed & cond_q & ~cond & long_enough;
      end
   end

   // R5: strobe is a single-clock pulse
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> !wr_strobe);
   // R6: no strobe unless power was good when it was decided
   strobe_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> $past(pg_s));
   // R7: a strobe needs an armed qualifier
   strobe_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> $past(armed));
   // R2: strobe only after the write combination ended
   strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> $past(cond_q) && !$past(cond));
endmodule

// File: tb/sim_wrq_gate.sv
module sim_wrq_gate;
   localparam int CLK_PERIOD = 10;
   localparam int MIN_CYC = 3;

   logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic wr_strobe, rd_mode_rst;
   int checks = 0, errors = 0;
   int n_stb = 0, n_rd = 0, n_wide = 0;
   logic stb_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wrq_gate #(.MIN_CYC(MIN_CYC), .STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .oe_n(oe_n),
      .we_n(we_n), .wr_strobe(wr_strobe), .rd_mode_rst(rd_mode_rst));

   always @(negedge clk) begin
      if (wr_strobe) n_stb++;
      if (rd_mode_rst) n_rd++;
      if (wr_strobe && stb_prev) n_wide++;
      stb_prev = wr_strobe;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pins(input logic c, input logic o, input logic w);
      ce_n = c; oe_n = o; we_n = w;
   endtask

   // base pins, then active pins for len clocks, back to base, then idle
   task automatic burst(input logic [2:0] base, input logic [2:0] act, input int len,
                        output int strobes);
      int s0;
      pins(base[2], base[1], base[0]); cyc(6);
      s0 = n_stb;
      pins(act[2], act[1], act[0]); cyc(len);
      pins(base[2], base[1], base[0]); cyc(8);
      pins(1'b1, 1'b1, 1'b1); cyc(6);
      strobes = n_stb - s0;
   endtask

   initial begin
      int got, r0;
      cyc(1);
      // R1: reset state
      check("R1 strobe", wr_strobe, 0);
      check("R1 rd_mode_rst", rd_mode_rst, 0);
      cyc(2); rst_n = 1'b1; cyc(3);
      check("R1 strobe after reset", wr_strobe, 0);
      check("R8 no pulse while power low", n_rd, 0);
      pwr_good = 1'b1; cyc(8);
      check("R8 one pulse on power-good rise", n_rd, 1);

      // R4 / R2: width sweep, three ways of opening the window ({ce,oe,we})
      for (int len = 1; len <= 6; len++) begin
         burst(3'b011, 3'b010, len, got);
         check($sformatf("R4 we_n pulse len %0d", len), got, (len >= MIN_CYC) ? 1 : 0);
         burst(3'b110, 3'b010, len, got);
         check($sformatf("R4 ce_n pulse len %0d", len), got, (len >= MIN_CYC) ? 1 : 0);
         burst(3'b000, 3'b010, len, got);
         check($sformatf("R4 oe_n high pulse len %0d", len), got, (len >= MIN_CYC) ? 1 : 0);
      end

      // R3 / R2: every pin combination held long
      for (int k = 0; k < 8; k++) begin
         burst(3'b111, 3'(k), 10, got);
         check($sformatf("R3 combo %0d", k), got, (k == 3'b010) ? 1 : 0);
      end

      // R5: every strobe seen so far was one clock wide
      check("R5 single-cycle strobe", n_wide, 0);

      // R6: power bad blocks writes
      pwr_good = 1'b0; cyc(6);
      burst(3'b111, 3'b010, 10, got);
      check("R6 write while power low", got, 0);

      // R7: write held across power-good rise is not accepted
      r0 = n_rd;
      pins(1'b0, 1'b1, 1'b0); cyc(6);
      got = n_stb;
      pwr_good = 1'b1; cyc(10);
      pins(1'b1, 1'b1, 1'b1); cyc(10);
      check("R7 held write at power-up", n_stb - got, 0);
      check("R8 pulse on second rise", n_rd - r0, 1);
      burst(3'b111, 3'b010, 5, got);
      check("R7 next write accepted", got, 1);
      check("R5 single-cycle strobe final", n_wide, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule